// File: doc/BRIEF.md
# Control-pin function decoder with qualified power-down

This block turns three static control pins into the internal enables of a line-signalling receiver. The pins pick one of four things: demodulation of the frequency-shift-keyed data stream on the line input, tone-alert detection on the line input, tone-alert detection on the handset-hybrid input, or an inactive state. The inactive state covers two codes, power-down and factory test. A selected function turns off the detector it does not use. The mode pin also picks between two ways of handing out the FSK data: a raw bit stream, or a buffered byte.

The pins are first brought into the clock domain and then decoded into registered enables. The power-down code does not act at once. It must hold steady for a set number of clocks before the block asserts power-down and removes the analog enable. If the code goes away before that count is reached, the block emits a one-clock reset pulse to the core and does not power down. The block also drives the receiver's outward pins. Each one carries its detector's raw signal only while that detector is enabled, and holds a fixed idle level at all other times, power-down included.

Top module: `ctlpin_fn_decoder`

## Requirements
- R1: A change on the control pins is seen on the function enables three clock edges after the edge that first samples it: two synchroniser stages plus one decode register.
- R2: The pin code {mode,fsel_hi,fsel_lo} = x11 asserts fsk_en_o, and buf_mode_o then equals the mode pin. buf_mode_o is low whenever fsk_en_o is low.
- R3: The code x10 asserts hyb_tone_en_o, and ready_steer_n_o then carries tone_steer_n_raw_i.
- R4: The code x01 asserts tr_tone_en_o, and ready_steer_n_o then carries tone_steer_n_raw_i.
- R5: At most one of fsk_en_o, tr_tone_en_o and hyb_tone_en_o is high in any cycle.
- R6: The code 000 asserts test_mode_o with every function enable low.
- R7: The code 100 held for QUAL_CYCLES consecutive synchronised cycles asserts pdn_o and drops analog_en_o. analog_en_o is always the inverse of pdn_o.
- R8: The code 100 held for fewer than QUAL_CYCLES cycles and then left produces exactly one cycle of core_rst_o, and pdn_o stays low.
- R9: While pdn_o is high, data_o, ready_steer_n_o and carrier_n_o are high, and early_o and guard_o are low.
- R10: With FSK enabled, ready_steer_n_o follows fsk_ready_n_raw_i in buffered mode (mode pin 1) and is held high in stream mode (mode pin 0). With no function enabled it is high.
- R11: data_o and carrier_n_o carry their raw inputs only while fsk_en_o is high, and are otherwise held high. early_o and guard_o carry their raw inputs only while a tone detector is enabled, and are otherwise held low. Every pin output is registered one cycle behind its inputs and enables.
- R12: Leaving a qualified power-down clears pdn_o and produces no core_rst_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pin_i | input | 1 | Mode control pin (bit 2 of the code) |
| fsel_hi_i | input | 1 | Function select high pin (bit 1) |
| fsel_lo_i | input | 1 | Function select low pin (bit 0) |
| fsk_data_raw_i | input | 1 | Demodulator data output |
| fsk_ready_n_raw_i | input | 1 | Demodulator byte-ready, active low |
| fsk_carrier_n_raw_i | input | 1 | Carrier detect, active low |
| tone_early_raw_i | input | 1 | Raw tone-present indication |
| tone_guard_raw_i | input | 1 | Guard-timer drive |
| tone_steer_n_raw_i | input | 1 | Guard-qualified tone steering, active low |
| fsk_en_o | output | 1 | FSK demodulator enable |
| tr_tone_en_o | output | 1 | Line-input tone detector enable |
| hyb_tone_en_o | output | 1 | Hybrid-input tone detector enable |
| buf_mode_o | output | 1 | Buffered-byte interface selected |
| test_mode_o | output | 1 | Factory test code present |
| pdn_o | output | 1 | Qualified power-down |
| analog_en_o | output | 1 | Bias, amplifier and oscillator enable |
| core_rst_o | output | 1 | One-cycle core reset pulse |
| data_o | output | 1 | Serial data pin |
| ready_steer_n_o | output | 1 | Dual-purpose ready / steering pin, active low |
| carrier_n_o | output | 1 | Carrier detect pin, active low |
| early_o | output | 1 | Early steering pin |
| guard_o | output | 1 | Guard-time pin |

## Verification
The bench drives short visits to the power-down code of one cycle and of a few cycles. A qualifier that counts wrongly would power down here, or would emit no reset pulse or a pulse wider than one cycle. It then holds the code exactly long enough, and one cycle short of long enough, to catch an off-by-one in the qualification count. It also leaves power-down to catch a design that wrongly pulses reset on exit. The raw detector inputs toggle randomly on every cycle, so a function that leaks its outputs while disabled, or routes the wrong source onto the dual-purpose pin in either interface mode, shows as a mismatch against the model.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;
  typedef enum logic [1:0] {
    FSEL_OFF  = 2'b00,
    FSEL_TR   = 2'b01,
    FSEL_HYB  = 2'b10,
    FSEL_FSK  = 2'b11
  } fsel_e;

  typedef struct packed {
    logic fsk;
    logic tr;
    logic hyb;
    logic buf_mode;
    logic test;
  } fn_en_t;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_PDN = 3'b100;
endpackage

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/ctlpin_decode.sv
module ctlpin_decode
  import ctlpin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output fn_en_t            en_o
);
  fn_en_t nxt;
  fsel_e  fsel;

  assign fsel = fsel_e'(code_i[1:0]);

  always_comb begin
    nxt = '0;
    unique case (fsel)
      FSEL_FSK: begin
        nxt.fsk      = 1'b1;
        nxt.buf_mode = code_i[2];
      end
      FSEL_HYB: nxt.hyb  = 1'b1;
      FSEL_TR:  nxt.tr   = 1'b1;
      FSEL_OFF: nxt.test = ~code_i[2];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) en_o <= '0;
    else     en_o <= nxt;
  end

  assert_one_fn_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_o.fsk, en_o.tr, en_o.hyb}));
  assert_mode_needs_fsk_R2: assert property (@(posedge clk) disable iff (rst)
    en_o.buf_mode |-> en_o.fsk);
  assert_test_idle_R6: assert property (@(posedge clk) disable iff (rst)
    en_o.test |-> !(en_o.fsk || en_o.tr || en_o.hyb));
endmodule

// File: rtl/ctlpin_pdn_qual.sv
module ctlpin_pdn_qual
  import ctlpin_pkg::*;
#(
  parameter int QUAL_CYCLES = 3580
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  output logic              pdn_o,
  output logic              rst_pulse_o
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] held;
  logic             is_pdn_code;

  assign is_pdn_code = (code_i == CODE_PDN);

  always_ff @(posedge clk) begin
    if (rst) begin
      held        <= '0;
      pdn_o       <= 1'b0;
      rst_pulse_o <= 1'b0;
    end else if (is_pdn_code) begin
      rst_pulse_o <= 1'b0;
      if (!pdn_o) begin
        held <= held + 1'b1;
        if (held == LAST) pdn_o <= 1'b1;
      end
    end else begin
      rst_pulse_o <= (held != '0) && !pdn_o;
      held        <= '0;
      pdn_o       <= 1'b0;
    end
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    rst_pulse_o |=> !rst_pulse_o);
  assert_pulse_not_in_pdn_R8: assert property (@(posedge clk) disable iff (rst)
    rst_pulse_o |-> !pdn_o);
  assert_exit_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(pdn_o) |-> !rst_pulse_o);
  assert_qualified_entry_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pdn_o) |-> $past(held) == LAST);
endmodule

// File: rtl/ctlpin_out_gate.sv
module ctlpin_out_gate
  import ctlpin_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  fn_en_t en_i,
  input  logic   data_raw_i,
  input  logic   ready_n_raw_i,
  input  logic   carrier_n_raw_i,
  input  logic   early_raw_i,
  input  logic   guard_raw_i,
  input  logic   steer_n_raw_i,
  output logic   data_o,
  output logic   ready_steer_n_o,
  output logic   carrier_n_o,
  output logic   early_o,
  output logic   guard_o
);
  logic tone_on;
  logic dual_nxt;

  assign tone_on = en_i.tr | en_i.hyb;

  always_comb begin
    if (en_i.fsk)    dual_nxt = en_i.buf_mode ? ready_n_raw_i : 1'b1;
    else if (tone_on) dual_nxt = steer_n_raw_i;
    else             dual_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o          <= 1'b1;
      ready_steer_n_o <= 1'b1;
      carrier_n_o     <= 1'b1;
      early_o         <= 1'b0;
      guard_o         <= 1'b0;
    end else begin
      data_o          <= en_i.fsk ? data_raw_i : 1'b1;
      carrier_n_o     <= en_i.fsk ? carrier_n_raw_i : 1'b1;
      ready_steer_n_o <= dual_nxt;
      early_o         <= tone_on & early_raw_i;
      guard_o         <= tone_on & guard_raw_i;
    end
  end

  assert_tone_pins_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !(en_i.tr || en_i.hyb) |=> !early_o && !guard_o);
  assert_fsk_pins_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !en_i.fsk |=> data_o && carrier_n_o);
endmodule

// File: rtl/ctlpin_fn_decoder.sv
module ctlpin_fn_decoder
  import ctlpin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 3580
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_pin_i,
  input  logic fsel_hi_i,
  input  logic fsel_lo_i,
  input  logic fsk_data_raw_i,
  input  logic fsk_ready_n_raw_i,
  input  logic fsk_carrier_n_raw_i,
  input  logic tone_early_raw_i,
  input  logic tone_guard_raw_i,
  input  logic tone_steer_n_raw_i,
  output logic fsk_en_o,
  output logic tr_tone_en_o,
  output logic hyb_tone_en_o,
  output logic buf_mode_o,
  output logic test_mode_o,
  output logic pdn_o,
  output logic analog_en_o,
  output logic core_rst_o,
  output logic data_o,
  output logic ready_steer_n_o,
  output logic carrier_n_o,
  output logic early_o,
  output logic guard_o
);
  logic [CODE_W-1:0] code_s;
  fn_en_t            en;

  ctlpin_sync #(.W(CODE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({mode_pin_i, fsel_hi_i, fsel_lo_i}),
    .q_o (code_s)
  );

  ctlpin_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .code_i (code_s),
    .en_o   (en)
  );

  ctlpin_pdn_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .code_i      (code_s),
    .pdn_o       (pdn_o),
    .rst_pulse_o (core_rst_o)
  );

  ctlpin_out_gate u_out (
    .clk             (clk),
    .rst             (rst),
    .en_i            (en),
    .data_raw_i      (fsk_data_raw_i),
    .ready_n_raw_i   (fsk_ready_n_raw_i),
    .carrier_n_raw_i (fsk_carrier_n_raw_i),
    .early_raw_i     (tone_early_raw_i),
    .guard_raw_i     (tone_guard_raw_i),
    .steer_n_raw_i   (tone_steer_n_raw_i),
    .data_o          (data_o),
    .ready_steer_n_o (ready_steer_n_o),
    .carrier_n_o     (carrier_n_o),
    .early_o         (early_o),
    .guard_o         (guard_o)
  );

  assign fsk_en_o      = en.fsk;
  assign tr_tone_en_o  = en.tr;
  assign hyb_tone_en_o = en.hyb;
  assign buf_mode_o    = en.buf_mode;
  assign test_mode_o   = en.test;
  assign analog_en_o   = ~pdn_o;

  assert_pdn_pin_levels_R9: assert property (@(posedge clk) disable iff (rst)
    pdn_o |-> data_o && ready_steer_n_o && carrier_n_o && !early_o && !guard_o);
  assert_pdn_no_function_R7: assert property (@(posedge clk) disable iff (rst)
    pdn_o |-> !(fsk_en_o || tr_tone_en_o || hyb_tone_en_o || test_mode_o));
endmodule

// File: tb/ctlpin_fn_decoder_test.sv
module ctlpin_fn_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pin = 0, fhi = 0, flo = 0;
  logic r_data = 0, r_rdy = 1, r_cd = 1, r_est = 0, r_gt = 0, r_stn = 1;
  logic fsk_en, tr_en, hyb_en, bmode, tmode, pdn, aen, crst;
  logic d_o, rs_o, cd_o, est_o, gt_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_p1 [3], m_cs [3];
  bit m_fsk, m_tr, m_hyb, m_bm, m_test, m_pdn, m_pulse, m_prev_pdn;
  bit m_d, m_rs, m_cd, m_est, m_gt;
  int held;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlpin_fn_decoder #(.SYNC_STAGES(2), .QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst(rst), .mode_pin_i(mode_pin), .fsel_hi_i(fhi), .fsel_lo_i(flo),
    .fsk_data_raw_i(r_data), .fsk_ready_n_raw_i(r_rdy), .fsk_carrier_n_raw_i(r_cd),
    .tone_early_raw_i(r_est), .tone_guard_raw_i(r_gt), .tone_steer_n_raw_i(r_stn),
    .fsk_en_o(fsk_en), .tr_tone_en_o(tr_en), .hyb_tone_en_o(hyb_en),
    .buf_mode_o(bmode), .test_mode_o(tmode), .pdn_o(pdn), .analog_en_o(aen),
    .core_rst_o(crst), .data_o(d_o), .ready_steer_n_o(rs_o), .carrier_n_o(cd_o),
    .early_o(est_o), .guard_o(gt_o)
  );

  task automatic chk(input string req, input string what, input logic act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // behavioural model, evaluated newest stage first so each uses last cycle's values
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_p1[i] = 0; m_cs[i] = 0; end
      {m_fsk, m_tr, m_hyb, m_bm, m_test, m_pdn, m_pulse, m_prev_pdn} = '0;
      m_d = 1; m_rs = 1; m_cd = 1; m_est = 0; m_gt = 0; held = 0;
    end else begin
      bit tone;
      tone = m_tr || m_hyb;
      m_d   = m_fsk ? r_data : 1'b1;
      m_cd  = m_fsk ? r_cd : 1'b1;
      m_rs  = m_fsk ? (m_bm ? r_rdy : 1'b1) : (tone ? r_stn : 1'b1);
      m_est = tone && r_est;
      m_gt  = tone && r_gt;
      m_fsk  = m_cs[1] && m_cs[0];
      m_hyb  = m_cs[1] && !m_cs[0];
      m_tr   = !m_cs[1] && m_cs[0];
      m_bm   = m_fsk && m_cs[2];
      m_test = !m_cs[2] && !m_cs[1] && !m_cs[0];
      m_prev_pdn = m_pdn;
      if (m_cs[2] && !m_cs[1] && !m_cs[0]) begin
        m_pulse = 0;
        if (!m_pdn) begin held++; if (held == QUAL) m_pdn = 1; end
      end else begin
        m_pulse = (held > 0) && !m_pdn;
        held = 0; m_pdn = 0;
      end
      m_cs = m_p1;
      m_p1[2] = mode_pin; m_p1[1] = fhi; m_p1[0] = flo;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", "fsk_en", fsk_en, m_fsk);
      chk("R2", "buf_mode", bmode, m_bm);
      chk("R3", "hyb_en", hyb_en, m_hyb);
      chk("R4", "tr_en", tr_en, m_tr);
      chk("R5", "one_fn", ($countones({fsk_en, tr_en, hyb_en}) <= 1), 1'b1);
      chk("R6", "test_mode", tmode, m_test);
      chk("R7", "pdn", pdn, m_pdn);
      chk("R7", "analog_en", aen, !m_pdn);
      if (m_prev_pdn && !m_pdn) chk("R12", "core_rst_exit", crst, 1'b0);
      else                      chk("R8", "core_rst", crst, m_pulse);
      if (m_pdn) begin
        chk("R9", "data", d_o, 1'b1);
        chk("R9", "ready_steer", rs_o, 1'b1);
        chk("R9", "carrier", cd_o, 1'b1);
        chk("R9", "early", est_o, 1'b0);
        chk("R9", "guard", gt_o, 1'b0);
      end else begin
        chk("R11", "data", d_o, m_d);
        chk("R10", "ready_steer", rs_o, m_rs);
        chk("R11", "carrier", cd_o, m_cd);
        chk("R11", "early", est_o, m_est);
        chk("R11", "guard", gt_o, m_gt);
      end
    end
  end

  // random raw detector activity, changed away from the active edge
  always @(negedge clk) begin
    if (!rst) {r_data, r_rdy, r_cd, r_est, r_gt, r_stn} <= 6'($urandom);
  end

  task automatic set_code(input bit [2:0] c, input int n);
    @(negedge clk);
    {mode_pin, fhi, flo} = c;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6", "reset_fsk_en", fsk_en, 1'b0);
    chk("R7", "reset_pdn", pdn, 1'b0);
    chk("R9", "reset_data", d_o, 1'b1);
    @(negedge clk) rst = 1'b0;
    set_code(3'b000, 5);
    // R1: latency of exactly three edges from first sampling edge
    @(negedge clk) {mode_pin, fhi, flo} = 3'b111;
    @(negedge clk); @(negedge clk);
    chk("R1", "fsk_en_before", fsk_en, 1'b0);
    @(negedge clk);
    chk("R1", "fsk_en_after", fsk_en, 1'b1);
    set_code(3'b111, 30);
    set_code(3'b011, 30);
    set_code(3'b110, 30);
    set_code(3'b001, 30);
    set_code(3'b010, 20);
    set_code(3'b101, 20);
    set_code(3'b000, 20);
    set_code(3'b100, 1);          // one-cycle glitch -> reset pulse
    set_code(3'b111, 20);
    set_code(3'b100, 5);          // short visit -> reset pulse
    set_code(3'b001, 20);
    set_code(3'b100, QUAL - 1);   // one short of qualifying
    set_code(3'b011, 20);
    set_code(3'b100, QUAL);       // exactly qualifying
    set_code(3'b011, 20);
    set_code(3'b100, 60);         // long power-down
    set_code(3'b111, 30);         // exit, no pulse
    set_code(3'b100, 40);
    set_code(3'b000, 20);
    repeat (5) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule